// File: doc/BRIEF.md
# Serial FIFO and Interrupt Controller

This block sits between a register bus and a serial shift engine. It buffers outgoing words in a transmit FIFO and incoming words in a receive FIFO. Each FIFO holds 32 bytes: that is 32 words in 8-bit mode or 16 words in 16-bit mode. Software fills the transmit FIFO through a write window and drains the receive FIFO through a read window. It can read each FIFO's fill level in bytes. Writing zero to a level register empties that FIFO.

Six event sources feed a sticky status register that is cleared by writing one to a bit. The sources are receive trigger, transmit trigger, transfer end, transfer complete, overflow and underrun. A separate control register holds one enable bit per source, and a single interrupt line is raised when any enabled source is pending. The shift engine is not part of this block. It appears only as a request/valid pair on the transmit side, a push strobe on the receive side, and a completion pulse.

Top module: `serial_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty and both level registers read 0. The status register, the control register and the trigger register read 0, and `irq` is low.
- R2: Each write to the transmit window (offset 0x1C) queues one word. The engine receives the words in write order on `eng_tx_data`, one per `eng_tx_req` cycle. In 8-bit mode (`wide_mode`=0) only bits 7:0 are kept. The transmit level (offset 0x14) reads the word count in 8-bit mode and twice the word count in 16-bit mode.
- R3: Each `eng_rx_push` queues `eng_rx_data`, masked the same way as in R2. Reads of the receive window (offset 0x18) return the words in push order, and each read removes one word. The receive level (offset 0x10) reads bytes as in R2. A read of the window while the receive FIFO is empty returns 0 and leaves the level at 0.
- R4: Writing 0 to a level register empties that FIFO. Writing a non-zero value to a level register leaves the FIFO unchanged.
- R5: The trigger register (offset 0x20) bits 2:0 hold a code n, which selects a threshold of 2^n words; codes 6 and 7 act as 32. Status bit 0 is set when a push brings the receive count to the threshold, but only while control bit 19 is 1.
- R6: Status bit 9 (transfer end) is set when an engine pop leaves the transmit FIFO empty.
- R7: Status bit 4 (transmit trigger) is set when an engine pop brings the transmit count to half the capacity: 16 words in 8-bit mode, 8 words in 16-bit mode. Status bit 8 (transfer complete) is set by an `eng_done` pulse.
- R8: Status bit 12 (overflow) is set by an `eng_rx_push` while the receive FIFO is full, or by a transmit-window write while the transmit FIFO is full. In both cases the word is dropped and the level is unchanged.
- R9: Status bit 13 (underrun) is set by `eng_tx_req` while the transmit FIFO is empty and `send_mode` is 1. The same request with `send_mode` at 0 sets nothing.
- R10: Writing 1 to a status bit (offset 0x0C) clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear leaves the bit set.
- R11: Control register (offset 0x08) bits 13, 12, 9, 8, 4 and 0 enable the status bits at the same positions. `irq` is high exactly when some status bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of the receive window pops one word at the clock edge |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| wide_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| send_mode | input | 1 | 1 when the engine both transmits and receives |
| eng_tx_req | input | 1 | Engine takes one transmit word this cycle |
| eng_tx_data | output | 16 | Head of the transmit FIFO (0 when empty) |
| eng_tx_valid | output | 1 | Transmit FIFO holds at least one word |
| eng_rx_push | input | 1 | Engine delivers one received word |
| eng_rx_data | input | 16 | Received word |
| eng_done | input | 1 | Engine reports a completed transfer |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the status register in the same cycle: a software write-one-to-clear and a fresh hardware event on the same bit. The bench fills the receive FIFO to capacity. In one cycle it then pushes another word and writes 1 to the overflow bit. Reading the status afterwards must show overflow still set, and a later clear with no event present must remove it.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    // Register byte offsets (software decodes these)
    localparam logic [5:0] OFS_CTRL  = 6'h08;
    localparam logic [5:0] OFS_STAT  = 6'h0C;
    localparam logic [5:0] OFS_RXLVL = 6'h10;
    localparam logic [5:0] OFS_TXLVL = 6'h14;
    localparam logic [5:0] OFS_RXWIN = 6'h18;
    localparam logic [5:0] OFS_TXWIN = 6'h1C;
    localparam logic [5:0] OFS_TRIG  = 6'h20;

    // Status / enable bit positions
    localparam int BIT_RXTRG = 0;
    localparam int BIT_TXTRG = 4;
    localparam int BIT_XCMP  = 8;
    localparam int BIT_XEND  = 9;
    localparam int BIT_OVF   = 12;
    localparam int BIT_UNF   = 13;
    localparam int BIT_TRGEN = 19;

    localparam logic [31:0] IRQ_MASK = (32'h1 << BIT_RXTRG) | (32'h1 << BIT_TXTRG)
                                     | (32'h1 << BIT_XCMP)  | (32'h1 << BIT_XEND)
                                     | (32'h1 << BIT_OVF)   | (32'h1 << BIT_UNF);
    localparam logic [31:0] CTRL_MASK = IRQ_MASK | (32'h1 << BIT_TRGEN);

    typedef struct packed {
        logic unf;
        logic ovf;
        logic xend;
        logic xcmp;
        logic txtrg;
        logic rxtrg;
    } evt_t;

    function automatic logic [31:0] evt_to_word(evt_t e);
        logic [31:0] w;
        w            = '0;
        w[BIT_RXTRG] = e.rxtrg;
        w[BIT_TXTRG] = e.txtrg;
        w[BIT_XCMP]  = e.xcmp;
        w[BIT_XEND]  = e.xend;
        w[BIT_OVF]   = e.ovf;
        w[BIT_UNF]   = e.unf;
        return w;
    endfunction

    // Receive threshold in words for a 3-bit code: 2^n, saturating at 32
    function automatic logic [31:0] thr_words(logic [2:0] code);
        return (code > 3'd5) ? 32'd32 : (32'd1 << code);
    endfunction

endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [CW-1:0] cap,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(count));
endmodule

// File: rtl/sfi_irq.sv
module sfi_irq
    import sfi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] set_vec,
    input  logic [31:0] clr_vec,
    input  logic [31:0] en_vec,
    output logic [31:0] status,
    output logic        irq
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= ((status & ~clr_vec) | set_vec) & IRQ_MASK;
    end

    assign irq = |(status & en_vec);

    assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
        ((clr_vec & ~set_vec & IRQ_MASK) != '0) |=> ((status & $past(clr_vec & ~set_vec)) == '0));
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(status) & ~$past(clr_vec) & ~status) == '0);
endmodule

// File: rtl/serial_fifo_irq.sv
module serial_fifo_irq
    import sfi_pkg::*;
#(
    parameter int FIFO_BYTES = 32,
    localparam int CW        = $clog2(FIFO_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        wide_mode,
    input  logic        send_mode,
    input  logic        eng_tx_req,
    output logic [15:0] eng_tx_data,
    output logic        eng_tx_valid,
    input  logic        eng_rx_push,
    input  logic [15:0] eng_rx_data,
    input  logic        eng_done,
    output logic        irq
);
    logic [31:0] ctrl_q;
    logic [2:0]  trig_q;
    logic [31:0] status;
    logic [CW-1:0] cap, half;
    logic [15:0]   dmask;

    assign cap   = wide_mode ? CW'(FIFO_BYTES / 2) : CW'(FIFO_BYTES);
    assign half  = cap >> 1;
    assign dmask = wide_mode ? 16'hFFFF : 16'h00FF;

    // Bus decode
    logic wr_ctrl, wr_stat, wr_trig, tx_wr, rx_rd, tx_flush, rx_flush;
    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
    assign wr_trig  = bus_wr && (bus_addr == OFS_TRIG);
    assign tx_wr    = bus_wr && (bus_addr == OFS_TXWIN);
    assign rx_rd    = bus_rd && (bus_addr == OFS_RXWIN);
    assign tx_flush = bus_wr && (bus_addr == OFS_TXLVL) && (bus_wdata == '0);
    assign rx_flush = bus_wr && (bus_addr == OFS_RXLVL) && (bus_wdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            trig_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (wr_trig) trig_q <= bus_wdata[2:0];
        end
    end

    // FIFOs
    logic [15:0]   tx_head, rx_head;
    logic [CW-1:0] tx_cnt, rx_cnt, tx_next, rx_next;
    logic tx_full, tx_empty, tx_push_ok, tx_pop_ok;
    logic rx_full, rx_empty, rx_push_ok, rx_pop_ok;

    sfi_fifo #(.DEPTH(FIFO_BYTES), .W(16)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_flush), .cap(cap),
        .push(tx_wr), .push_data(bus_wdata[15:0] & dmask), .pop(eng_tx_req),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok));

    sfi_fifo #(.DEPTH(FIFO_BYTES), .W(16)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_flush), .cap(cap),
        .push(eng_rx_push), .push_data(eng_rx_data & dmask), .pop(rx_rd),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok));

    assign tx_next = tx_cnt + CW'(tx_push_ok) - CW'(tx_pop_ok);
    assign rx_next = rx_cnt + CW'(rx_push_ok) - CW'(rx_pop_ok);

    assign eng_tx_valid = !tx_empty;
    assign eng_tx_data  = tx_empty ? 16'h0 : tx_head;

    // Events
    evt_t ev;
    always_comb begin
        ev.rxtrg = rx_push_ok && ctrl_q[BIT_TRGEN] && (32'(rx_next) == thr_words(trig_q));
        ev.txtrg = tx_pop_ok && (tx_next == half);
        ev.xend  = tx_pop_ok && (tx_next == '0);
        ev.xcmp  = eng_done;
        ev.ovf   = (eng_rx_push && rx_full) || (tx_wr && tx_full);
        ev.unf   = eng_tx_req && send_mode && tx_empty;
    end

    sfi_irq u_irq (
        .clk(clk), .rst(rst),
        .set_vec(evt_to_word(ev)),
        .clr_vec(wr_stat ? bus_wdata : 32'h0),
        .en_vec(ctrl_q & IRQ_MASK),
        .status(status), .irq(irq));

    // Read mux
    function automatic logic [31:0] lvl_bytes(logic [CW-1:0] c, logic wide);
        logic [CW:0] b;
        b = wide ? {c, 1'b0} : {1'b0, c};
        return 32'(b);
    endfunction

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL:  bus_rdata = ctrl_q;
                OFS_STAT:  bus_rdata = status;
                OFS_RXLVL: bus_rdata = lvl_bytes(rx_cnt, wide_mode);
                OFS_TXLVL: bus_rdata = lvl_bytes(tx_cnt, wide_mode);
                OFS_RXWIN: bus_rdata = rx_empty ? 32'h0 : {16'h0, rx_head};
                OFS_TRIG:  bus_rdata = {29'h0, trig_q};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == OFS_RXWIN) && !eng_tx_req && rx_empty) |-> (bus_rdata == '0));
    assert_underrun_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_req && send_mode && !eng_tx_valid) |=> status[BIT_UNF]);
    assert_xfer_done_flag_R7: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> status[BIT_XCMP]);
endmodule

// File: tb/serial_fifo_irq_tb.sv
`timescale 1ns/1ps
module serial_fifo_irq_tb;
    import sfi_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wide_mode = 0, send_mode = 0;
    logic        eng_tx_req = 0, eng_rx_push = 0, eng_done = 0;
    logic [15:0] eng_rx_data = '0;
    logic [15:0] eng_tx_data;
    logic        eng_tx_valid, irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    serial_fifo_irq u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wide_mode(wide_mode),
        .send_mode(send_mode), .eng_tx_req(eng_tx_req), .eng_tx_data(eng_tx_data),
        .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_done(eng_done), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks begin and end at a falling edge
    task automatic bwr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic brd(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic epush(input logic [15:0] d);
        eng_rx_push = 1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 0;
    endtask

    task automatic epop(output logic [15:0] d);
        eng_tx_req = 1;
        #1 d = eng_tx_data;
        @(negedge clk);
        eng_tx_req = 0;
    endtask

    task automatic t_reset;
        brd(OFS_TXLVL, rv); chk("R1 tx level", rv, 0);
        brd(OFS_RXLVL, rv); chk("R1 rx level", rv, 0);
        brd(OFS_STAT, rv);  chk("R1 status", rv, 0);
        brd(OFS_CTRL, rv);  chk("R1 control", rv, 0);
        brd(OFS_TRIG, rv);  chk("R1 trigger", rv, 0);
        chk("R1 irq", {31'h0, irq}, 0);
    endtask

    task automatic t_tx_order;
        logic [15:0] d;
        bwr(OFS_TXWIN, 32'h1A5); bwr(OFS_TXWIN, 32'h22); bwr(OFS_TXWIN, 32'h33);
        brd(OFS_TXLVL, rv); chk("R2 tx level 8-bit", rv, 3);
        epop(d); chk("R2 first word masked", {16'h0, d}, 32'hA5);
        epop(d); chk("R2 second word", {16'h0, d}, 32'h22);
        brd(OFS_STAT, rv); chk("R6 no end while data left", rv & 32'h200, 0);
        epop(d); chk("R2 third word", {16'h0, d}, 32'h33);
        brd(OFS_STAT, rv); chk("R6 transfer end on drain", rv & 32'h200, 32'h200);
        bwr(OFS_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_wide;
        logic [15:0] d;
        wide_mode = 1;
        bwr(OFS_TXWIN, 32'hBEEF); bwr(OFS_TXWIN, 32'h1234);
        brd(OFS_TXLVL, rv); chk("R2 tx level 16-bit bytes", rv, 4);
        bwr(OFS_TXLVL, 32'h5);
        brd(OFS_TXLVL, rv); chk("R4 nonzero level write ignored", rv, 4);
        epop(d); chk("R2 16-bit word", {16'h0, d}, 32'hBEEF);
        bwr(OFS_TXLVL, 32'h0);
        brd(OFS_TXLVL, rv); chk("R4 tx flush", rv, 0);
        chk("R4 tx valid after flush", {31'h0, eng_tx_valid}, 0);
        wide_mode = 0;
        bwr(OFS_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_rx;
        epush(16'h1211); epush(16'h0022);
        brd(OFS_RXLVL, rv); chk("R3 rx level", rv, 2);
        brd(OFS_RXWIN, rv); chk("R3 first rx word masked", rv, 32'h11);
        brd(OFS_RXWIN, rv); chk("R3 second rx word", rv, 32'h22);
        brd(OFS_RXWIN, rv); chk("R3 empty read zero", rv, 0);
        brd(OFS_RXLVL, rv); chk("R3 level after empty read", rv, 0);
        epush(16'h77); epush(16'h78);
        bwr(OFS_RXLVL, 32'h0);
        brd(OFS_RXLVL, rv); chk("R4 rx flush", rv, 0);
    endtask

    task automatic t_trigger;
        bwr(OFS_TRIG, 32'h2);   // 4 words
        for (int i = 0; i < 4; i++) epush(16'(i));
        brd(OFS_STAT, rv); chk("R5 no trigger without enable", rv & 32'h1, 0);
        bwr(OFS_RXLVL, 32'h0);
        bwr(OFS_CTRL, 32'h0008_0001);
        for (int i = 0; i < 3; i++) epush(16'(i));
        brd(OFS_STAT, rv); chk("R5 below threshold", rv & 32'h1, 0);
        chk("R11 irq low below threshold", {31'h0, irq}, 0);
        epush(16'h9);
        brd(OFS_STAT, rv); chk("R5 trigger at 4 words", rv & 32'h1, 32'h1);
        chk("R11 irq on enabled source", {31'h0, irq}, 1);
        bwr(OFS_STAT, 32'h1);
        brd(OFS_STAT, rv); chk("R10 w1c clears", rv, 0);
        chk("R11 irq drops after clear", {31'h0, irq}, 0);
        bwr(OFS_RXLVL, 32'h0);
        bwr(OFS_TRIG, 32'h0);   // 1 word
        epush(16'h5);
        brd(OFS_STAT, rv); chk("R5 code 0 threshold 1", rv & 32'h1, 32'h1);
        bwr(OFS_CTRL, 32'h0);
        bwr(OFS_RXLVL, 32'h0);
        bwr(OFS_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow;
        logic [15:0] d;
        for (int i = 0; i < 32; i++) epush(16'(i + 1));
        brd(OFS_STAT, rv); chk("R8 no overflow at capacity", rv & 32'h1000, 0);
        epush(16'hEE);
        brd(OFS_STAT, rv); chk("R8 rx overflow", rv & 32'h1000, 32'h1000);
        brd(OFS_RXLVL, rv); chk("R8 rx level unchanged", rv, 32);
        // clear and new event in the same cycle
        bus_wr = 1; bus_addr = OFS_STAT; bus_wdata = 32'h1000;
        eng_rx_push = 1; eng_rx_data = 16'hEF;
        @(negedge clk);
        bus_wr = 0; eng_rx_push = 0;
        brd(OFS_STAT, rv); chk("R10 event beats clear", rv & 32'h1000, 32'h1000);
        bwr(OFS_STAT, 32'h1000);
        brd(OFS_STAT, rv); chk("R10 clear alone", rv & 32'h1000, 0);
        brd(OFS_RXWIN, rv); chk("R8 dropped word not stored", rv, 1);
        bwr(OFS_RXLVL, 32'h0);
        for (int i = 0; i < 32; i++) bwr(OFS_TXWIN, 32'(i));
        bwr(OFS_TXWIN, 32'hAB);
        brd(OFS_STAT, rv); chk("R8 tx overflow", rv & 32'h1000, 32'h1000);
        brd(OFS_TXLVL, rv); chk("R8 tx level unchanged", rv, 32);
        for (int i = 0; i < 15; i++) epop(d);
        brd(OFS_STAT, rv); chk("R7 no tx trigger above half", rv & 32'h10, 0);
        epop(d);
        brd(OFS_STAT, rv); chk("R7 tx trigger at half", rv & 32'h10, 32'h10);
        bwr(OFS_TXLVL, 32'h0);
        bwr(OFS_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_underrun;
        logic [15:0] d;
        send_mode = 0;
        epop(d);
        brd(OFS_STAT, rv); chk("R9 no underrun in receive-only", rv & 32'h2000, 0);
        send_mode = 1;
        epop(d);
        brd(OFS_STAT, rv); chk("R9 underrun on empty request", rv & 32'h2000, 32'h2000);
        bwr(OFS_CTRL, 32'h2000);
        chk("R11 irq from underrun", {31'h0, irq}, 1);
        bwr(OFS_CTRL, 32'h0);
        chk("R11 irq masked", {31'h0, irq}, 0);
        send_mode = 0;
        eng_done = 1; @(negedge clk); eng_done = 0;
        brd(OFS_STAT, rv); chk("R7 transfer complete", rv, 32'h2100);
        bwr(OFS_STAT, 32'h0);
        brd(OFS_STAT, rv); chk("R10 zero write no effect", rv, 32'h2100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_tx_order();
        t_wide();
        t_rx();
        t_trigger();
        t_overflow();
        t_underrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule